// File: doc/BRIEF.md
# DRAM Self-Refresh Entry and Exit Sequencer

This block takes a memory controller's DRAM into and out of low-power self refresh. When the controller requests entry, the block checks that the refresh scheduler is idle. It then drives a refresh command with clock enable low for one cycle, which puts the device into self refresh. From then on it holds clock enable low and keeps the command bus at NOP. In this mode the device ignores every pin except clock enable.

Leaving self refresh takes two steps. First a wake request must arrive. Then the clock must be reported stable, and only after that is clock enable raised. Two cycle counters start on the cycle that clock enable goes high. One measures the NOP-only exit window; once it expires, normal commands may resume. The other measures the longer DLL relock window; once it expires, reads may resume. A mode input selects a simpler policy in which all commands wait for the full relock window.

Top module: `selfref_sequencer`

## Requirements
- R1: During and after reset, `cke` is 1, `cmd` is NOP (4'b0111, bits {cs_n, ras_n, cas_n, we_n}), and `cmd_ok` and `read_ok` are both 1.
- R2: Entry is accepted on a clock edge that samples `sr_req` high and `sched_busy` low while `cmd_ok` is 1. After that edge, `cke` is 0 and `cmd` is the refresh code 4'b0001 for exactly one cycle. `cmd` is NOP after that.
- R3: While `sched_busy` is 1, no entry is accepted: `cke` stays 1 and `cmd` stays NOP.
- R4: From entry until exit, `cke` stays 0 and `cmd` stays NOP. `sr_req` has no effect in this period. A `wake_req` that is sampled on the entry edge, or on the refresh-command cycle, is ignored.
- R5: `cke` goes back to 1 one cycle after the first edge that samples `clk_stable` high, counted from the edge after the one that samples `wake_req`. `cke` never rises before the wake request.
- R6: In normal mode (`slow_mode` = 0 when `cke` rises), `cmd_ok` goes to 1 exactly XSNR_CYC cycles after `cke` rises.
- R7: `read_ok` goes to 1 exactly DLL_CYC cycles after `cke` rises. It is 0 at the moment `cmd_ok` rises in normal mode.
- R8: In slow mode (`slow_mode` = 1 when `cke` rises), `cmd_ok` also waits DLL_CYC cycles, so it rises together with `read_ok`.
- R9: Whenever `cke` is 0, `cmd_ok` and `read_ok` are both 0.
- R10: While `cmd_ok` is 0, an `sr_req` is not accepted. If `sr_req` is held through an exit, the refresh command appears on the cycle after `cmd_ok` rises. `read_ok` stays 0 through the new entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| sr_req | input | 1 | Request to enter self refresh (level) |
| sched_busy | input | 1 | Refresh scheduler busy; blocks entry |
| wake_req | input | 1 | Request to leave self refresh |
| clk_stable | input | 1 | Clock is stable; allows clock enable to rise |
| slow_mode | input | 1 | 1 holds all commands for the full DLL relock window |
| cke | output | 1 | DRAM clock enable |
| cmd | output | 4 | Command bus {cs_n, ras_n, cas_n, we_n} |
| cmd_ok | output | 1 | Normal commands may be issued |
| read_ok | output | 1 | Read commands may be issued |

## Verification
Every output is a register. The refresh code and the low clock enable therefore appear one cycle after the accepting edge, and `cke` rises one cycle after the edge that sees `clk_stable`. The bench drives inputs and samples outputs one time unit after each rising edge, so each sample shows the state right after that edge. From the sample where `cke` first reads 1, the bench counts edges and expects `cmd_ok` at exactly XSNR_CYC (DLL_CYC in slow mode) and `read_ok` at exactly DLL_CYC. A held re-entry request must show the refresh code one edge after `cmd_ok` first reads 1.

// File: rtl/selfref_pkg.sv
package selfref_pkg;

  localparam int CMD_W = 4;

  // command bus bits: {cs_n, ras_n, cas_n, we_n}
  localparam logic [CMD_W-1:0] CMD_NOP = 4'b0111;
  localparam logic [CMD_W-1:0] CMD_REF = 4'b0001;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_ENTER    = 3'd1,
    ST_IN_SR    = 3'd2,
    ST_WAIT_CLK = 3'd3,
    ST_EXIT_NOP = 3'd4,
    ST_READY    = 3'd5
  } sr_state_t;

endpackage

// File: rtl/selfref_wait_cnt.sv
// Down-counter: done rises exactly `limit` cycles after the load edge.
module selfref_wait_cnt #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          load,
  input  logic [CW-1:0] limit,
  output logic          done
);

  logic [CW-1:0] cnt;
  logic          run;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      run  <= 1'b0;
      done <= 1'b1;
    end else if (clr) begin
      cnt  <= '0;
      run  <= 1'b0;
      done <= 1'b0;
    end else if (load) begin
      cnt  <= limit - 1'b1;
      run  <= 1'b1;
      done <= 1'b0;
    end else if (run) begin
      if (cnt == '0) begin
        run  <= 1'b0;
        done <= 1'b1;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

endmodule

// File: rtl/selfref_fsm.sv
module selfref_fsm
  import selfref_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             sr_req,
  input  logic             sched_busy,
  input  logic             wake_req,
  input  logic             clk_stable,
  input  logic             cmd_done,
  output logic             go_enter,
  output logic             go_exit,
  output logic             cke,
  output logic [CMD_W-1:0] cmd
);

  sr_state_t st, nxt;
  logic      can_enter;

  assign can_enter = sr_req && !sched_busy;

  always_comb begin
    nxt      = st;
    go_enter = 1'b0;
    go_exit  = 1'b0;
    case (st)
      ST_IDLE, ST_READY: begin
        if (can_enter) begin
          nxt      = ST_ENTER;
          go_enter = 1'b1;
        end
      end
      ST_ENTER:    nxt = ST_IN_SR;
      ST_IN_SR:    if (wake_req) nxt = ST_WAIT_CLK;
      ST_WAIT_CLK: begin
        if (clk_stable) begin
          nxt     = ST_EXIT_NOP;
          go_exit = 1'b1;
        end
      end
      ST_EXIT_NOP: begin
        if (cmd_done) begin
          if (can_enter) begin
            nxt      = ST_ENTER;
            go_enter = 1'b1;
          end else begin
            nxt = ST_READY;
          end
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= ST_IDLE;
      cke <= 1'b1;
      cmd <= CMD_NOP;
    end else begin
      st  <= nxt;
      cke <= !((nxt == ST_ENTER) || (nxt == ST_IN_SR) || (nxt == ST_WAIT_CLK));
      cmd <= (nxt == ST_ENTER) ? CMD_REF : CMD_NOP;
    end
  end

endmodule

// File: rtl/selfref_sequencer.sv
module selfref_sequencer
  import selfref_pkg::*;
#(
  parameter int XSNR_CYC = 10,
  parameter int DLL_CYC  = 200
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sr_req,
  input  logic             sched_busy,
  input  logic             wake_req,
  input  logic             clk_stable,
  input  logic             slow_mode,
  output logic             cke,
  output logic [CMD_W-1:0] cmd,
  output logic             cmd_ok,
  output logic             read_ok
);

  localparam int CW   = $clog2(DLL_CYC + 1);
  localparam int NCNT = 2;   // 0: command window, 1: read window

  logic            go_enter, go_exit;
  logic [NCNT-1:0] done;
  logic [CW-1:0]   lim [NCNT];

  assign lim[0] = slow_mode ? CW'(DLL_CYC) : CW'(XSNR_CYC);
  assign lim[1] = CW'(DLL_CYC);

  selfref_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .sr_req    (sr_req),
    .sched_busy(sched_busy),
    .wake_req  (wake_req),
    .clk_stable(clk_stable),
    .cmd_done  (done[0]),
    .go_enter  (go_enter),
    .go_exit   (go_exit),
    .cke       (cke),
    .cmd       (cmd)
  );

  for (genvar i = 0; i < NCNT; i++) begin : g_win
    selfref_wait_cnt #(.CW(CW)) u_cnt (
      .clk  (clk),
      .rst  (rst),
      .clr  (go_enter),
      .load (go_exit),
      .limit(lim[i]),
      .done (done[i])
    );
  end

  assign cmd_ok  = done[0];
  assign read_ok = done[1];

endmodule

// File: rtl/selfref_sequencer_chk.sv
module selfref_sequencer_chk
  import selfref_pkg::*;
#(
  parameter int XSNR_CYC = 10,
  parameter int DLL_CYC  = 200
) (
  input logic             clk,
  input logic             rst,
  input logic             sr_req,
  input logic             sched_busy,
  input logic             clk_stable,
  input logic             cke,
  input logic [CMD_W-1:0] cmd,
  input logic             cmd_ok,
  input logic             read_ok
);

  logic [15:0] since_up;

  always_ff @(posedge clk) begin
    if (rst || !cke) since_up <= '0;
    else if (since_up != 16'hFFFF) since_up <= since_up + 1'b1;
  end

  assert_ref_cke_low_R2: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_REF) |-> !cke);

  assert_ref_single_R2: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_REF) |=> (cmd == CMD_NOP));

  assert_busy_blocks_R3: assert property (@(posedge clk) disable iff (rst)
    (cke && sched_busy) |=> (cmd != CMD_REF));

  assert_cke_needs_stable_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(cke) |-> $past(clk_stable));

  assert_low_cke_nop_R4: assert property (@(posedge clk) disable iff (rst)
    (!cke && $past(!cke)) |-> (cmd == CMD_NOP));

  assert_read_window_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(read_ok) |-> (since_up == 16'(DLL_CYC)));

  assert_cmd_window_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(cmd_ok) |-> ((since_up == 16'(XSNR_CYC)) || (since_up == 16'(DLL_CYC))));

  assert_read_after_cmd_R8: assert property (@(posedge clk) disable iff (rst)
    read_ok |-> cmd_ok);

  assert_low_cke_gates_R9: assert property (@(posedge clk) disable iff (rst)
    !cke |-> (!cmd_ok && !read_ok));

  assert_no_entry_unready_R10: assert property (@(posedge clk) disable iff (rst)
    !cmd_ok |=> (cmd != CMD_REF));

endmodule

bind selfref_sequencer selfref_sequencer_chk #(
  .XSNR_CYC(XSNR_CYC),
  .DLL_CYC (DLL_CYC)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .sr_req    (sr_req),
  .sched_busy(sched_busy),
  .clk_stable(clk_stable),
  .cke       (cke),
  .cmd       (cmd),
  .cmd_ok    (cmd_ok),
  .read_ok   (read_ok)
);

// File: tb/selfref_sequencer_test.sv
`timescale 1ns/1ps
module selfref_sequencer_test;

  localparam int CLK_PERIOD = 10;
  localparam int TB_XSNR    = 12;
  localparam int TB_DLL     = 200;
  localparam logic [3:0] NOP = 4'b0111;
  localparam logic [3:0] REF = 4'b0001;

  // vector: {slow, cycles in self refresh before wake, cycles before clk_stable}
  localparam int NVEC = 4;
  localparam logic [8:0] VEC [NVEC] = '{
    {1'b0, 4'd2, 4'd0},
    {1'b0, 4'd5, 4'd3},
    {1'b1, 4'd1, 4'd2},
    {1'b1, 4'd0, 4'd6}
  };

  logic clk = 1'b0;
  logic rst, sr_req, sched_busy, wake_req, clk_stable, slow_mode;
  logic cke, cmd_ok, read_ok;
  logic [3:0] cmd;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  selfref_sequencer #(.XSNR_CYC(TB_XSNR), .DLL_CYC(TB_DLL)) uut (
    .clk(clk), .rst(rst), .sr_req(sr_req), .sched_busy(sched_busy),
    .wake_req(wake_req), .clk_stable(clk_stable), .slow_mode(slow_mode),
    .cke(cke), .cmd(cmd), .cmd_ok(cmd_ok), .read_ok(read_ok)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // enter self refresh with sr_req pulsed; checks R2 and R4
  task automatic enter_sr();
    sr_req = 1'b1;
    step();
    chk("R2 cke low on entry", cke, 0);
    chk("R2 refresh code", cmd, REF);
    sr_req = 1'b0;
    step();
    chk("R2 NOP after refresh", cmd, NOP);
    chk("R4 cke held low", cke, 0);
  endtask

  // wake and wait for cke; returns once cke reads 1
  task automatic wake_up(input int stab);
    wake_req = 1'b1;
    step();
    wake_req = 1'b0;
    for (int i = 0; i < stab; i++) begin
      step();
      chk("R5 cke waits for clk_stable", cke, 0);
    end
    clk_stable = 1'b1;
    step();
    chk("R5 cke rises after clk_stable", cke, 1);
    clk_stable = 1'b0;
  endtask

  // count edges from cke rise to each ok output
  task automatic measure(input bit slow);
    int k = 0;
    while (!cmd_ok && k < 400) begin
      step();
      k++;
    end
    if (slow) chk("R8 slow-mode cmd_ok delay", k, TB_DLL);
    else begin
      chk("R6 cmd_ok delay", k, TB_XSNR);
      chk("R7 read_ok low at cmd_ok", read_ok, 0);
    end
    while (!read_ok && k < 400) begin
      step();
      k++;
    end
    chk("R7 read_ok delay", k, TB_DLL);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1; sr_req = 1'b0; sched_busy = 1'b0; wake_req = 1'b0;
    clk_stable = 1'b0; slow_mode = 1'b0;
    step(); step();
    chk("R1 cke in reset", cke, 1);
    chk("R1 cmd in reset", cmd, NOP);
    rst = 1'b0;
    step();
    chk("R1 cmd_ok after reset", cmd_ok, 1);
    chk("R1 read_ok after reset", read_ok, 1);

    // table walk
    for (int v = 0; v < NVEC; v++) begin
      slow_mode = VEC[v][8];
      enter_sr();
      chk("R9 cmd_ok low in self refresh", cmd_ok, 0);
      chk("R9 read_ok low in self refresh", read_ok, 0);
      for (int h = 0; h < int'(VEC[v][7:4]); h++) begin
        step();
        chk("R4 cke low while idle in self refresh", cke, 0);
      end
      wake_up(int'(VEC[v][3:0]));
      measure(VEC[v][8]);
      slow_mode = 1'b0;
      step();
    end

    // R3: busy scheduler blocks entry
    sched_busy = 1'b1;
    sr_req = 1'b1;
    for (int i = 0; i < 3; i++) begin
      step();
      chk("R3 cke stays high while busy", cke, 1);
      chk("R3 cmd stays NOP while busy", cmd, NOP);
    end
    sr_req = 1'b0;
    sched_busy = 1'b0;
    step();

    // R4: early wake and held sr_req are ignored; clk_stable alone does nothing
    wake_req = 1'b1;
    sr_req = 1'b1;
    clk_stable = 1'b1;
    step();
    chk("R2 entry with early wake", cmd, REF);
    step();
    wake_req = 1'b0;
    for (int i = 0; i < 4; i++) begin
      step();
      chk("R4 early wake ignored", cke, 0);
      chk("R4 sr_req ignored in self refresh", cmd, NOP);
    end
    sr_req = 1'b0;
    clk_stable = 1'b0;
    wake_up(1);

    // R10: request held through exit is accepted only once cmd_ok rises
    sr_req = 1'b1;
    begin
      int k = 0;
      while (!cmd_ok && k < 400) begin
        chk("R10 no entry before cmd_ok", cmd, NOP);
        step();
        k++;
      end
      chk("R6 cmd_ok delay before re-entry", k, TB_XSNR);
    end
    step();
    chk("R10 re-entry refresh code", cmd, REF);
    chk("R10 read_ok stays low on re-entry", read_ok, 0);
    chk("R10 cke low on re-entry", cke, 0);
    sr_req = 1'b0;
    step();
    wake_up(0);
    measure(1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule